// File: doc/BRIEF.md
# Warm-Reboot Command Word Sequencer

This block turns a single trigger into the fixed script of 16-bit words that makes an FPGA's internal configuration port reload the device from a new flash location. When the trigger is taken, the block captures a 24-bit primary boot address, a 24-bit fallback boot address and an 8-bit opcode byte. It then sends fourteen words, one at a time, over a valid/ready handshake to a lower-level port driver. That driver owns the port clock, the chip enable and the read/write direction.

The script has three phases. The sync phase sends a dummy word and two synchronisation words. The general-register phase sends four header/payload pairs that load the two boot addresses. The command phase sends the command-register header, the reboot command and a trailing no-op. Header words are assembled from their fields, not stored. Every outgoing word has its bits mirrored inside each byte, which is the bit order the port expects.

The state machine has five states. ST_IDLE waits for the trigger. ST_SYNC, ST_GENREG and ST_COMMAND present the words of their phases. ST_DONE lasts one cycle and raises the done pulse. The transitions are as follows:
- IDLE->SYNC on a trigger.
- SYNC->GENREG after the third word is accepted.
- GENREG->COMMAND after the eleventh word is accepted.
- COMMAND->DONE after the fourteenth word is accepted.
- DONE->IDLE unconditionally.
- Any state goes to IDLE on reset.

Top module: `warmboot_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, word_valid, busy and done are all low.
- R2: A trigger seen in ST_IDLE is accepted at that clock edge. From the next cycle, busy and word_valid are high and the first word is presented.
- R3: Before bit mirroring, the fourteen words are sent in this order (index 0 to 13):
  - 0xFFFF, 0xAA99, 0x5566
  - 0x3261, primary[15:0]
  - 0x3281, {opcode, primary[23:16]}
  - 0x32A1, fallback[15:0]
  - 0x32C1, {opcode, fallback[23:16]}
  - 0x30A1, 0x000E, 0x2000
- R4: Word 4 carries primary[15:0] and word 8 carries fallback[15:0], as captured at the trigger.
- R5: Words 6 and 10 carry the captured opcode byte in bits [15:8]. Bits [7:0] hold primary[23:16] and fallback[23:16] respectively.
- R6: Every header word (indices 3, 5, 7, 9, 11) has bits [15:13]=001, bits [12:11]=10 (write) and bits [4:0]=1. Bits [10:5] hold the register number: 0x13, 0x14, 0x15, 0x16 and 0x05 respectively.
- R7: word_data bit 8*b+i equals bit 8*b+7-i of the script word, for each byte b and bit i. Byte positions are unchanged.
- R8: A word advances only on a cycle with word_valid and word_ready both high. While word_ready is low, word_valid stays high and word_data holds its value.
- R9: A trigger, or a change of the address and opcode inputs, during a sequence has no effect on the words sent.
- R10: done is high for exactly one cycle, the cycle after the trailing no-op is accepted. busy is high in that cycle and low in the next.
- R11: Reset asserted mid-sequence returns the block to idle, with word_valid and busy low after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start request, sampled in idle |
| boot_addr | input | 24 | Primary boot address |
| fallback_addr | input | 24 | Fallback boot address |
| opcode_byte | input | 8 | Byte placed above the high address bits |
| word_valid | output | 1 | A word is presented |
| word_ready | input | 1 | Downstream accepts the word |
| word_data | output | 16 | Bit-mirrored script word |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
A wrong phase or a wrong word index shows up at the very next accepted word, as a wrong value in the scoreboard comparison. A slip between phase states shows up as a wrong header value. A stuck-high handshake or index advance shows up during the first stall of ready, as a changed word while ready is low. A missing or doubled done pulse, or a late drop of busy, shows up within two cycles of the last handshake.

// File: rtl/warmboot_pkg.sv
package warmboot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNC    = 3'd1,
        ST_GENREG  = 3'd2,
        ST_COMMAND = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_t;

    localparam logic [15:0] W_DUMMY  = 16'hFFFF;
    localparam logic [15:0] W_SYNC_A = 16'hAA99;
    localparam logic [15:0] W_SYNC_B = 16'h5566;
    localparam logic [15:0] W_REBOOT = 16'h000E;
    localparam logic [15:0] W_NOOP   = 16'h2000;

    localparam logic [5:0] REG_GEN1 = 6'h13;
    localparam logic [5:0] REG_GEN2 = 6'h14;
    localparam logic [5:0] REG_GEN3 = 6'h15;
    localparam logic [5:0] REG_GEN4 = 6'h16;
    localparam logic [5:0] REG_CMD  = 6'h05;

    // Single-word write header: packet type, opcode, register, count.
    function automatic logic [15:0] wr_header(input logic [5:0] regnum);
        return {3'b001, 2'b10, regnum, 5'd1};
    endfunction

endpackage

// File: rtl/warmboot_script.sv
module warmboot_script
    import warmboot_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 24,
    parameter int OP_W   = 8,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] boot_q,
    input  logic [ADDR_W-1:0] fall_q,
    input  logic [OP_W-1:0]   op_q,
    output logic [WORD_W-1:0] word
);
    localparam int LO_W = WORD_W;
    localparam int HI_W = ADDR_W - LO_W;

    logic [WORD_W-1:0] boot_lo, boot_hi, fall_lo, fall_hi;

    always_comb begin
        boot_lo = boot_q[LO_W-1:0];
        fall_lo = fall_q[LO_W-1:0];
        boot_hi = {op_q, boot_q[ADDR_W-1:LO_W]};
        fall_hi = {op_q, fall_q[ADDR_W-1:LO_W]};
    end

    always_comb begin
        unique case (idx)
            4'd0:    word = W_DUMMY;
            4'd1:    word = W_SYNC_A;
            4'd2:    word = W_SYNC_B;
            4'd3:    word = wr_header(REG_GEN1);
            4'd4:    word = boot_lo;
            4'd5:    word = wr_header(REG_GEN2);
            4'd6:    word = boot_hi;
            4'd7:    word = wr_header(REG_GEN3);
            4'd8:    word = fall_lo;
            4'd9:    word = wr_header(REG_GEN4);
            4'd10:   word = fall_hi;
            4'd11:   word = wr_header(REG_CMD);
            4'd12:   word = W_REBOOT;
            default: word = W_NOOP;
        endcase
    end

    logic unused_hi_w;
    assign unused_hi_w = (HI_W + OP_W != WORD_W);
endmodule

// File: rtl/warmboot_bitrev.sv
module warmboot_bitrev #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b + i] = din[8*b + 7 - i];
        end
    end
endmodule

// File: rtl/warmboot_seq.sv
module warmboot_seq
    import warmboot_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 24,
    parameter int OP_W      = 8,
    parameter int NUM_WORDS = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [ADDR_W-1:0] boot_addr,
    input  logic [ADDR_W-1:0] fallback_addr,
    input  logic [OP_W-1:0]   opcode_byte,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [IDX_W-1:0] SYNC_LAST   = IDX_W'(2);
    localparam logic [IDX_W-1:0] GENREG_LAST = IDX_W'(10);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(NUM_WORDS - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] boot_q, fall_q;
    logic [OP_W-1:0]   op_q;
    logic              take;
    logic              accept;
    logic [WORD_W-1:0] raw_word;

    assign take   = word_valid && word_ready;
    assign accept = (state_q == ST_IDLE) && trig;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig) state_d = ST_SYNC;
            ST_SYNC:    if (take && idx_q == SYNC_LAST) state_d = ST_GENREG;
            ST_GENREG:  if (take && idx_q == GENREG_LAST) state_d = ST_COMMAND;
            ST_COMMAND: if (take && idx_q == LAST_IDX) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register, index and captured fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            boot_q  <= '0;
            fall_q  <= '0;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q  <= '0;
                boot_q <= boot_addr;
                fall_q <= fallback_addr;
                op_q   <= opcode_byte;
            end else if (take && idx_q != LAST_IDX) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        word_valid = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SYNC, ST_GENREG, ST_COMMAND: begin
                word_valid = 1'b1;
                busy       = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    warmboot_script #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .IDX_W(IDX_W)
    ) u_script (
        .idx(idx_q), .boot_q(boot_q), .fall_q(fall_q), .op_q(op_q),
        .word(raw_word)
    );

    warmboot_bitrev #(.WORD_W(WORD_W)) u_rev (
        .din(raw_word), .dout(word_data)
    );
endmodule

// File: rtl/warmboot_seq_chk.sv
module warmboot_seq_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              word_valid,
    input logic              word_ready,
    input logic [WORD_W-1:0] word_data,
    input logic              busy,
    input logic              done
);
    // R8: a stalled word stays valid and unchanged
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done follows a handshake and busy drops next
    p_done_after_take_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(word_valid && word_ready));
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R2: valid implies busy; the first word is the dummy
    p_valid_busy_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> busy);
    p_first_word_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid) |-> (word_data == {WORD_W{1'b1}}));

    // R10: done and valid never overlap
    p_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !word_valid);
endmodule

bind warmboot_seq warmboot_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .busy(busy), .done(done)
);

// File: tb/warmboot_seq_test.sv
module warmboot_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [23:0] boot_addr = '0;
    logic [23:0] fallback_addr = '0;
    logic [7:0]  opcode_byte = '0;
    logic        word_valid;
    logic        word_ready = 1'b1;
    logic [15:0] word_data;
    logic        busy;
    logic        done;

    int errors = 0;
    int checks = 0;
    int stall_mode = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    int          idx_q[$];

    always #2 clk = ~clk;   // 250 MHz

    warmboot_seq uut (
        .clk(clk), .rst(rst), .trig(trig), .boot_addr(boot_addr),
        .fallback_addr(fallback_addr), .opcode_byte(opcode_byte),
        .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .busy(busy), .done(done)
    );

    function automatic logic [15:0] mirror(input logic [15:0] w);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = w[(i/8)*8 + 7 - (i%8)];
        return r;
    endfunction

    function automatic string tag_of(input int i);
        if (i == 4 || i == 8) return "R4";
        if (i == 6 || i == 10) return "R5";
        if (i == 3 || i == 5 || i == 7 || i == 9 || i == 11) return "R6";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard driver: push the expected script
    task automatic push_script(input logic [23:0] b, input logic [23:0] f, input logic [7:0] op);
        logic [15:0] w[14];
        w[0] = 16'hFFFF; w[1] = 16'hAA99; w[2] = 16'h5566;
        w[3] = 16'h3261; w[4] = b[15:0];
        w[5] = 16'h3281; w[6] = {op, b[23:16]};
        w[7] = 16'h32A1; w[8] = f[15:0];
        w[9] = 16'h32C1; w[10] = {op, f[23:16]};
        w[11] = 16'h30A1; w[12] = 16'h000E; w[13] = 16'h2000;
        for (int k = 0; k < 14; k++) begin
            exp_q.push_back(mirror(w[k]));   // R7 mirror per byte
            idx_q.push_back(k);
        end
    endtask

    // Monitor: compare every accepted word, and check holds during stalls
    logic        prev_stall = 1'b0;
    logic [15:0] prev_word = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_stall = 1'b0;
            end else begin
                if (prev_stall)
                    check(word_valid && word_data == prev_word, "R8", word_data, prev_word);
                if (word_valid && word_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", word_data, 0);
                    end else begin
                        automatic logic [15:0] e = exp_q.pop_front();
                        automatic int k = idx_q.pop_front();
                        check(word_data == e, tag_of(k), word_data, e);
                    end
                end
                prev_stall = word_valid && !word_ready;
                prev_word  = word_data;
            end
        end
    end

    // Ready driver: low for random spans in stall mode
    initial begin
        int low_left = 0;
        forever begin
            @(posedge clk); #1;
            if (stall_mode == 0) word_ready = 1'b1;
            else if (low_left > 0) begin word_ready = 1'b0; low_left--; end
            else begin word_ready = 1'b1; low_left = $urandom % 6; end
        end
    end

    task automatic run_seq(input logic [23:0] b, input logic [23:0] f,
                           input logic [7:0] op, input bit glitch);
        int guard = 0;
        push_script(b, f, op);
        @(posedge clk); #1;
        trig = 1'b1; boot_addr = b; fallback_addr = f; opcode_byte = op;
        @(posedge clk); #1;
        trig = 1'b0;
        boot_addr = ~b; fallback_addr = ~f; opcode_byte = ~op;   // R9 inputs change
        check(busy && word_valid, "R2", {busy, word_valid}, 2'b11);
        if (glitch) begin
            repeat (4) begin @(posedge clk); #1; end
            trig = 1'b1;                                          // R9 retrigger
            @(posedge clk); #1;
            trig = 1'b0;
        end
        while (exp_q.size() != 0 && guard < 2000) begin
            @(posedge clk); #1; guard++;
        end
        check(guard < 2000, "R10", guard, 0);
        check(done && busy && !word_valid, "R10", {done, busy, word_valid}, 3'b110);
        @(posedge clk); #1;
        check(!done && !busy, "R10", {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (3) begin @(posedge clk); #1; end
        check(!word_valid && !busy && !done, "R1", {word_valid, busy, done}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(!word_valid && !busy && !done, "R1", {word_valid, busy, done}, 0);

        run_seq(24'h123456, 24'hABCDEF, 8'h0B, 1'b0);
        stall_mode = 1;
        run_seq(24'h000000, 24'hFFFFFF, 8'hA5, 1'b0);
        run_seq(24'h80F001, 24'h7E0C3D, 8'h3C, 1'b1);
        run_seq(24'h5A5A5A, 24'hC3C3C3, 8'hFF, 1'b0);

        // R11: reset mid-sequence
        push_script(24'h111111, 24'h222222, 8'h01);
        @(posedge clk); #1;
        trig = 1'b1; boot_addr = 24'h111111; fallback_addr = 24'h222222; opcode_byte = 8'h01;
        @(posedge clk); #1;
        trig = 1'b0;
        repeat (5) begin @(posedge clk); #1; end
        rst = 1'b1;
        @(posedge clk); #1;
        check(!word_valid && !busy && !done, "R11", {word_valid, busy, done}, 0);
        rst = 1'b0;
        exp_q.delete(); idx_q.delete();
        @(posedge clk); #1;
        check(!word_valid && !busy, "R11", {word_valid, busy}, 0);

        stall_mode = 0;
        run_seq(24'hFEDCBA, 24'h013579, 8'h0B, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule